// File: doc/BRIEF.md
# Strap-addressed I2C target

This block is a byte-wide I2C target that runs on a fast system clock and watches the SCL and SDA lines through synchronisers. It pulls SDA low through an open-drain enable and never drives SCL. The master always generates the clock, and bytes move most significant bit first. The target answers at one 7-bit address. The top four bits of that address are fixed at 1001. The low three bits come from two strap inputs, and each strap has already been resolved to one of three levels. The nine strap combinations therefore select eight addresses, from 0x48 to 0x4F.

Each transaction carries exactly one data byte and no register pointer. In a write, the master sends the address with R/W = 0 and then one byte. The target acknowledges both bytes and presents the data byte on a one-cycle strobe. In a read, the master sends the address with R/W = 1. The target acknowledges, takes a byte from its external read input at that acknowledge, and shifts the byte out. The master then ends the read with a NACK. The straps are sampled again at every START, so the address can be changed while the system runs.

Top module: `i2c_strap_target`

## Requirements
- R1: While reset is held and in the first cycles after reset, `sda_oe` is 0 and `wr_valid` is 0.
- R2: Each strap is coded 2'b00 = low, 2'b01 = mid, 2'b10 = high, and 2'b11 is also taken as high. With n = 3·level(strap_hi) + level(strap_lo), where low = 0, mid = 1 and high = 2, the target address is 0x48 + min(n, 7). This gives LL = 0x48 and HM = HH = 0x4F.
- R3: A matching address byte with R/W = 0 (bit 0) is acknowledged, and so is the data byte that follows it. After the eighth data bit, `wr_data` holds that byte while `wr_valid` is high for exactly one clock.
- R4: The strap inputs are captured at each START. A strap change after a START does not affect that transaction, and the new address applies from the next START onward.
- R5: A matching address byte with R/W = 1 is acknowledged. `rd_data` is captured when that acknowledge begins, and the captured byte is driven MSB first over the next eight clocks. SDA is then released for the master's acknowledge bit.
- R6: After an address byte that does not match, the target drives no acknowledge, leaves SDA released and produces no write strobe until the next START.
- R7: In a write, every data byte after the first is not acknowledged and produces no strobe.
- R8: A repeated START at any point returns the target to the address phase, and the new address byte is decoded in full.
- R9: A STOP releases SDA and makes the target idle. Bits clocked after a STOP with no START are ignored.
- R10: `sda_oe` changes only while SCL is low. An acknowledge is held through the whole ninth clock and released after that clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_hi | input | 2 | Upper address strap level |
| strap_lo | input | 2 | Lower address strap level |
| wr_data | output | 8 | Byte received in a write |
| wr_valid | output | 1 | One-cycle strobe for `wr_data` |
| rd_data | input | 8 | Byte returned in a read |

## Verification
A wrong state or a wrong bit count shows up at SDA within one SCL bit time. It appears as a missing or misplaced acknowledge bit seen by the master, or as a shifted read byte. An address captured wrongly, or captured at the wrong moment, shows up as an acknowledge to the wrong address at the ninth clock of that same transaction. A strobe that is lost or duplicated, or that fires on a NACKed byte, shows at `wr_valid` within a few system clocks after the eighth data bit.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;

  // strap code to numeric level: 00 low, 01 mid, 10/11 high
  function automatic logic [1:0] strap_level(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe;
  logic [MSB:0] sda_pipe;
  logic         scl_d;
  logic         sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
      scl_d    <= scl_pipe[MSB];
      sda_d    <= sda_pipe[MSB];
    end
  end

  assign scl_s     = scl_pipe[MSB];
  assign sda_s     = sda_pipe[MSB];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/strap_addr_map.sv
module strap_addr_map
  import i2c_strap_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b1001
) (
  input  logic [1:0] strap_hi,
  input  logic [1:0] strap_lo,
  output logic [6:0] addr
);
  logic [3:0] combo;

  always_comb begin
    combo = {2'b00, strap_level(strap_hi)} * 4'd3 + {2'b00, strap_level(strap_lo)};
    if (combo > 4'd7) addr = {ADDR_PREFIX[3:0], 3'd7};
    else              addr = {ADDR_PREFIX[3:0], combo[2:0]};
  end
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import i2c_strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        strap_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [6:0]        addr_q;
  logic              rd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      addr_q   <= '0;
      rd_mode  <= 1'b0;
      sda_oe   <= 1'b0;
      wr_data  <= '0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        addr_q  <= strap_addr;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              if (rx_sh[BYTE_W-1:1] == addr_q) begin
                sda_oe  <= 1'b1;
                rd_mode <= rx_sh[0];
                state   <= ST_ADDR_ACK;
                if (rx_sh[0]) tx_sh <= rd_data;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                state  <= ST_RDATA;
                sda_oe <= ~tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end else begin
                state  <= ST_WDATA;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              wr_data  <= rx_sh;
              wr_valid <= 1'b1;
              sda_oe   <= 1'b1;
              state    <= ST_WDATA_ACK;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_IGNORE;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) state <= ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_strap_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b1001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_hi,
  input  logic [1:0]        strap_lo,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid,
  input  logic [BYTE_W-1:0] rd_data
);
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic [6:0] strap_addr;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  strap_addr_map #(.ADDR_PREFIX(ADDR_PREFIX)) u_map (
    .strap_hi(strap_hi), .strap_lo(strap_lo), .addr(strap_addr)
  );

  i2c_byte_fsm u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .strap_addr(strap_addr),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_data(wr_data), .wr_valid(wr_valid)
  );

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_valid,
  input logic start_det,
  input logic stop_det
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i); // R10

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R3

  AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> sda_oe); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R9

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe); // R8
endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (.*);

// File: tb/i2c_strap_target_test.sv
`timescale 1ns/1ps
module i2c_strap_target_test;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap_hi = 2'b00;
  logic [1:0] strap_lo = 2'b00;
  logic [7:0] rd_data = 8'h00;
  logic       sda_oe;
  logic [7:0] wr_data;
  logic       wr_valid;
  logic       sda_line;

  int errors = 0;
  int checks = 0;
  int wr_count = 0;
  logic [7:0] wr_last = 8'h00;
  int oe_bad = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_strap_target uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_hi(strap_hi), .strap_lo(strap_lo), .wr_data(wr_data),
    .wr_valid(wr_valid), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (!rst && wr_valid) begin
      wr_count <= wr_count + 1;
      wr_last  <= wr_data;
    end
    if (!rst && (sda_oe !== oe_prev) && scl_m) oe_bad <= oe_bad + 1;
    oe_prev <= sda_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hq; scl_m = 1'b1; hq; sda_m = 1'b0; hq; scl_m = 1'b0; hq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hq; scl_m = 1'b1; hq; sda_m = 1'b1; hq;
  endtask

  task automatic bit_xfer(input logic b, output logic seen);
    sda_m = b; hq; scl_m = 1'b1; hq; seen = sda_line; hq; scl_m = 1'b0; hq;
  endtask

  task automatic byte_out(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic byte_in(output logic [7:0] v, input logic master_bit);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      v[i] = s;
    end
    bit_xfer(master_bit, s);
  endtask

  function automatic logic [6:0] exp_addr(input int hi, input int lo);
    int n = hi * 3 + lo;
    if (n > 7) n = 7;
    return 7'h48 + 7'(n);
  endfunction

  task automatic t_reset;
    check("R1 sda_oe in reset", sda_oe, 0);
    check("R1 wr_valid in reset", wr_valid, 0);
    rst = 1'b0;
    hq;
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 wr_valid after reset", wr_valid, 0);
  endtask

  task automatic t_write_combos;
    logic ack;
    int c0;
    for (int hi = 0; hi < 3; hi++) begin
      for (int lo = 0; lo < 3; lo++) begin
        strap_hi = 2'(hi); strap_lo = 2'(lo);
        c0 = wr_count;
        bus_start;
        byte_out({exp_addr(hi, lo), 1'b0}, ack);
        check($sformatf("R2 ack addr %0d/%0d", hi, lo), ack, 1);
        byte_out(8'(8'h81 + hi * 16 + lo), ack);
        check("R3 data ack", ack, 1);
        bus_stop;
        check("R3 one strobe", wr_count - c0, 1);
        check("R3 data value", wr_last, 8'h81 + hi * 16 + lo);
      end
    end
    strap_hi = 2'b11; strap_lo = 2'b00;
    bus_start;
    byte_out({7'h4E, 1'b0}, ack);
    check("R2 code 11 as high", ack, 1);
    byte_out(8'h00, ack);
    bus_stop;
  endtask

  task automatic t_mismatch;
    logic ack;
    int c0 = wr_count;
    strap_hi = 2'b00; strap_lo = 2'b00;
    bus_start;
    byte_out({7'h49, 1'b0}, ack);
    check("R6 no ack wrong addr", ack, 0);
    byte_out(8'h00, ack);
    check("R6 no ack following byte", ack, 0);
    bus_stop;
    check("R6 no strobe", wr_count - c0, 0);
  endtask

  task automatic t_read(input logic [1:0] hi, input logic [1:0] lo,
                        input logic [6:0] a, input logic [7:0] v);
    logic ack;
    logic [7:0] got;
    strap_hi = hi; strap_lo = lo;
    rd_data = v;
    bus_start;
    byte_out({a, 1'b1}, ack);
    check("R5 read addr ack", ack, 1);
    rd_data = ~v;
    byte_in(got, 1'b1);
    check("R5 read byte", got, v);
    bus_stop;
    hq;
    check("R9 released after stop", sda_oe, 0);
  endtask

  task automatic t_extra_bytes;
    logic ack;
    int c0 = wr_count;
    strap_hi = 2'b01; strap_lo = 2'b00;
    bus_start;
    byte_out({7'h4B, 1'b0}, ack);
    byte_out(8'h3C, ack);
    check("R7 first byte ack", ack, 1);
    byte_out(8'h00, ack);
    check("R7 second byte nack", ack, 0);
    bus_stop;
    check("R7 one strobe only", wr_count - c0, 1);
    check("R7 kept first byte", wr_last, 8'h3C);
  endtask

  task automatic t_strap_change;
    logic ack;
    strap_hi = 2'b00; strap_lo = 2'b01;
    bus_start;
    strap_hi = 2'b10; strap_lo = 2'b00;
    byte_out({7'h49, 1'b0}, ack);
    check("R4 start-time address kept", ack, 1);
    byte_out(8'h55, ack);
    bus_stop;
    bus_start;
    byte_out({7'h49, 1'b0}, ack);
    check("R4 old address dropped", ack, 0);
    bus_stop;
    bus_start;
    byte_out({7'h4E, 1'b0}, ack);
    check("R4 new address taken", ack, 1);
    byte_out(8'h66, ack);
    bus_stop;
  endtask

  task automatic t_restart;
    logic ack;
    logic [7:0] got;
    strap_hi = 2'b00; strap_lo = 2'b00;
    rd_data = 8'hC3;
    bus_start;
    byte_out({7'h48, 1'b0}, ack);
    bus_start;
    byte_out({7'h48, 1'b1}, ack);
    check("R8 restart read ack", ack, 1);
    byte_in(got, 1'b1);
    check("R8 restart read byte", got, 8'hC3);
    bus_start;
    byte_out({7'h4A, 1'b0}, ack);
    check("R8 mismatch after restart", ack, 0);
    bus_start;
    byte_out({7'h48, 1'b0}, ack);
    check("R8 restart after mismatch", ack, 1);
    byte_out(8'h12, ack);
    bus_stop;
  endtask

  task automatic t_stop_idle;
    logic ack;
    strap_hi = 2'b00; strap_lo = 2'b00;
    scl_m = 1'b0; hq;
    byte_out({7'h48, 1'b0}, ack);
    check("R9 no ack without start", ack, 0);
    bus_stop;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    hq;
    t_write_combos;
    t_mismatch;
    t_read(2'b01, 2'b01, 7'h4C, 8'hA5);
    t_read(2'b10, 2'b01, 7'h4F, 8'h5A);
    t_extra_bytes;
    t_strap_change;
    t_restart;
    t_stop_idle;
    check("R10 sda_oe changes only with SCL low", oe_bad, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule